// File: doc/BRIEF.md
# Dual Clock Frequency Comparator

This block checks whether a test clock runs at the expected rate relative to a trusted reference clock. Two seeded down-counters start together. One counts reference cycles and then opens a short acceptance window. The other counts cycles of a test clock, picked from several sources. The test clock passes only if its counter runs out while the window is open. Both expiry points are set by seeds, so the check is a ratio test and works for any reference frequency. Software usually runs it once, before it switches the system onto a newly started clock.

Each run is a single shot. Software writes the seeds and the source select while the comparator is disabled. It then writes an enable key and polls the status word until it is nonzero. Bit 0 of that word is the fail flag. The test-domain counter is started by a reference-domain run level that passes through a two-flop synchronizer. Its expiry flag comes back to the reference domain through a second two-flop synchronizer before any decision is made.

Register addresses: 0 control (enable key in bits 3:0), 1 status, 2 reference seed, 3 window seed, 4 test seed, 5 source select (select in the low bits, key in bits 15:12).

Top module: `clkcmp_top`

## Requirements
- R1: After reset the status word reads 0, `done_o` and `err_o` are low, and the control word reads back the disable key 0x5.
- R2: A control key of 0x5 disables the comparator. Any other 4-bit value enables it, including corrupted values such as 0x3. A measurement starts only when the comparator goes from disabled to enabled. Rewriting a key while it is already enabled does not restart it.
- R3: If the test counter expires while the reference window is open, status bit 1 (done) is set and bit 0 stays clear.
- R4: If the test counter expires before the reference counter reaches zero, status bit 0 (error) is set and bit 1 stays clear.
- R5: If the reference window closes before the test counter expires, status bit 0 (error) is set.
- R6: Writing the status word clears each flag whose bit is written as 1. Flags whose bit is written as 0 keep their value.
- R7: A write to the source-select word takes effect only when bits 15:12 hold 0xA. Any other key leaves the select unchanged.
- R8: While the comparator is enabled, writes to the three seed words and to the source select are ignored.
- R9: Disabling the comparator during a measurement aborts it, and no flag is set.
- R10: A measurement produces at most one result. After that, no new flag appears until the comparator is disabled and enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, also clocks the register port |
| rst | input | 1 | Synchronous active-high reset |
| tclk | input | N_SRC | Candidate test clocks |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for `addr`, one cycle after the address |
| done_o | output | 1 | Status done flag (pass) |
| err_o | output | 1 | Status error flag (fail) |

## Verification
The bench aims test clocks at both edges of the acceptance window. A design that compares against the wrong counter phase would pass a clock that is too fast or fail one that is on target. A design that does not separate an early expiry from a missed window would flag only one of the two failure modes. It also aborts a run part way through: a comparator without a clean abort would later raise a stale result. It rewrites the enable key while the comparator is already enabled, which shows whether the run is triggered by the key transition or by its level. Further checks cover keyed writes, locked seed writes and per-bit clearing. An implementation that treats unknown keys as disabled, or that clears the whole status word on any write, would change the readback.

// File: rtl/clkcmp_pkg.sv
package clkcmp_pkg;
  localparam logic [3:0] KEY_OFF = 4'h5;
  localparam logic [3:0] KEY_ON  = 4'hA;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_REF  = 3'd2;
  localparam logic [2:0] A_WIN  = 3'd3;
  localparam logic [2:0] A_TST  = 3'd4;
  localparam logic [2:0] A_SRC  = 3'd5;

  localparam int ERR_BIT  = 0;
  localparam int DONE_BIT = 1;
  localparam int SKEY_LSB = 12;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_COUNT,
    S_WIN,
    S_DONE
  } ref_state_e;
endpackage

// File: rtl/clkcmp_sync.sv
module clkcmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/clkcmp_regs.sv
module clkcmp_regs
  import clkcmp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pass_p,
  input  logic              fail_p,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic [CNT_W-1:0]  ref_seed,
  output logic [CNT_W-1:0]  win_seed,
  output logic [CNT_W-1:0]  tst_seed,
  output logic [SEL_W-1:0]  src_sel,
  output logic              done,
  output logic              err
);
  logic [3:0]        key_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_stat, wr_src_ok;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:CNT_W];
  assign en        = (key_q != KEY_OFF);
  assign wr_stat   = wr_en && (addr == A_STAT);
  assign wr_src_ok = wr_en && (addr == A_SRC) && !en &&
                     (wdata[SKEY_LSB+3:SKEY_LSB] == KEY_ON);

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: rd_mux[3:0]       = key_q;
      A_STAT: begin
        rd_mux[ERR_BIT]  = err;
        rd_mux[DONE_BIT] = done;
      end
      A_REF:  rd_mux[CNT_W-1:0] = ref_seed;
      A_WIN:  rd_mux[CNT_W-1:0] = win_seed;
      A_TST:  rd_mux[CNT_W-1:0] = tst_seed;
      A_SRC:  rd_mux[SEL_W-1:0] = src_sel;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q    <= KEY_OFF;
      ref_seed <= '0;
      win_seed <= '0;
      tst_seed <= '0;
      src_sel  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
    end else begin
      rdata <= rd_mux;
      if (wr_en && addr == A_CTRL) key_q <= wdata[3:0];
      if (wr_en && !en) begin
        case (addr)
          A_REF:   ref_seed <= wdata[CNT_W-1:0];
          A_WIN:   win_seed <= wdata[CNT_W-1:0];
          A_TST:   tst_seed <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (wr_src_ok) src_sel <= wdata[SEL_W-1:0];
      if (fail_p)                        err <= 1'b1;
      else if (wr_stat && wdata[ERR_BIT]) err <= 1'b0;
      if (pass_p)                         done <= 1'b1;
      else if (wr_stat && wdata[DONE_BIT]) done <= 1'b0;
    end
  end

  // R3 / R4: a single run never raises both flags
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  // R6: a one clears the error flag
  a_r6_w1c_err: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata[ERR_BIT] && !fail_p) |=> !err);
  // R6: a zero leaves the done flag alone
  a_r6_keep_done: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !wdata[DONE_BIT] && done) |=> done);
  // R7: a wrong key leaves the selection unchanged
  a_r7_src_key: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SRC && wdata[SKEY_LSB+3:SKEY_LSB] != KEY_ON) |=> $stable(src_sel));
  // R8: configuration is frozen while enabled
  a_r8_seed_lock: assert property (@(posedge clk) disable iff (rst)
    (en && wr_en) |=> ($stable(ref_seed) && $stable(win_seed) &&
                       $stable(tst_seed) && $stable(src_sel)));
endmodule

// File: rtl/clkcmp_test_cnt.sv
module clkcmp_test_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             tclk,
  input  logic             rst,
  input  logic             run_s,
  input  logic [CNT_W-1:0] seed,
  output logic             tdone
);
  logic             run_q;
  logic             active;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge tclk) begin
    if (rst) begin
      run_q  <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      tdone  <= 1'b0;
    end else begin
      run_q <= run_s;
      if (!run_s) begin
        active <= 1'b0;
        cnt    <= '0;
        tdone  <= 1'b0;
      end else if (!run_q) begin
        cnt    <= seed;
        active <= 1'b1;
      end else if (active) begin
        if (cnt == '0) begin
          tdone  <= 1'b1;
          active <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R10: expiry is held until the run level drops
  a_r10_tdone_hold: assert property (@(posedge tclk) disable iff (rst)
    (tdone && run_s) |=> tdone);
  // R3: the test counter never runs while the expiry is set
  a_r3_no_count_after: assert property (@(posedge tclk) disable iff (rst)
    tdone |-> !active);
endmodule

// File: rtl/clkcmp_ref_ctl.sv
module clkcmp_ref_ctl
  import clkcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] ref_seed,
  input  logic [CNT_W-1:0] win_seed,
  input  logic             tdone_s,
  output logic             run,
  output logic             pass_p,
  output logic             fail_p
);
  ref_state_e       state;
  logic [CNT_W-1:0] cnt0;
  logic [CNT_W-1:0] win;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt0   <= '0;
      win    <= '0;
      run    <= 1'b0;
      pass_p <= 1'b0;
      fail_p <= 1'b0;
    end else begin
      pass_p <= 1'b0;
      fail_p <= 1'b0;
      if (!en) begin
        state <= S_IDLE;
        run   <= 1'b0;
      end else begin
        case (state)
          S_IDLE: state <= S_ARM;
          S_ARM: if (!tdone_s) begin
            cnt0  <= ref_seed;
            win   <= win_seed;
            run   <= 1'b1;
            state <= S_COUNT;
          end
          S_COUNT: begin
            if (tdone_s) begin
              fail_p <= 1'b1;
              state  <= S_DONE;
            end else if (cnt0 == '0) begin
              state <= S_WIN;
            end else begin
              cnt0 <= cnt0 - 1'b1;
            end
          end
          S_WIN: begin
            if (tdone_s) begin
              pass_p <= 1'b1;
              state  <= S_DONE;
            end else if (win == '0) begin
              fail_p <= 1'b1;
              state  <= S_DONE;
            end else begin
              win <= win - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: no result one cycle after the comparator is disabled
  a_r9_abort: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(pass_p || fail_p));
  // R3 / R4 / R5: one result pulse at a time
  a_r3_one_result: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pass_p, fail_p}));
  // R10: a result is followed by the finished or idle state
  a_r10_single_shot: assert property (@(posedge clk) disable iff (rst)
    (pass_p || fail_p) |-> (state == S_DONE || state == S_IDLE));
  // R10: no second result while finished
  a_r10_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (pass_p || fail_p) |=> !(pass_p || fail_p));
endmodule

// File: rtl/clkcmp_top.sv
module clkcmp_top
  import clkcmp_pkg::*;
#(
  parameter int N_SRC       = 4,
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  tclk,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done_o,
  output logic              err_o
);
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             en, run, run_s, tdone, tdone_s;
  logic             pass_p, fail_p;
  logic [CNT_W-1:0] ref_seed, win_seed, tst_seed;
  logic [SEL_W-1:0] src_sel;
  logic             tclk_sel;

  assign tclk_sel = tclk[src_sel];

  clkcmp_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pass_p(pass_p), .fail_p(fail_p), .rdata(rdata), .en(en),
    .ref_seed(ref_seed), .win_seed(win_seed), .tst_seed(tst_seed),
    .src_sel(src_sel), .done(done_o), .err(err_o)
  );

  clkcmp_ref_ctl #(.CNT_W(CNT_W)) u_ref (
    .clk(clk), .rst(rst), .en(en), .ref_seed(ref_seed), .win_seed(win_seed),
    .tdone_s(tdone_s), .run(run), .pass_p(pass_p), .fail_p(fail_p)
  );

  clkcmp_sync #(.STAGES(SYNC_STAGES)) u_sync_run (
    .clk(tclk_sel), .rst(rst), .d(run), .q(run_s)
  );

  clkcmp_test_cnt #(.CNT_W(CNT_W)) u_tst (
    .tclk(tclk_sel), .rst(rst), .run_s(run_s), .seed(tst_seed), .tdone(tdone)
  );

  clkcmp_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
    .clk(clk), .rst(rst), .d(tdone), .q(tdone_s)
  );
endmodule

// File: tb/sim_clkcmp_top.sv
`timescale 1ns/100ps
module sim_clkcmp_top;
  localparam int NV = 7;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_REF = 3'd2,
                         A_WIN = 3'd3, A_TST = 3'd4, A_SRC = 3'd5;
  // test clock periods: src0 4.0 ns, src1 5.6 ns, src2 8.0 ns, src3 10.0 ns
  localparam int V_SRC [NV] = '{1, 0, 2, 3, 0, 3, 1};
  localparam int V_REF [NV] = '{138, 138, 138, 50, 138, 40, 200};
  localparam int V_WIN [NV] = '{10, 10, 10, 10, 10, 5, 20};
  localparam int V_TST [NV] = '{489, 489, 489, 100, 700, 100, 100};
  // expected status: 2 = done (pass), 1 = error
  localparam int V_EXP [NV] = '{2, 1, 1, 2, 2, 1, 1};

  logic        clk = 1'b0, rst = 1'b1;
  logic [3:0]  tclk = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        done_o, err_o;
  int          checks = 0, errors = 0;
  logic [31:0] rv;

  always #10   clk = ~clk;
  always #2.0  tclk[0] = ~tclk[0];
  always #2.8  tclk[1] = ~tclk[1];
  always #4.0  tclk[2] = ~tclk[2];
  always #5.0  tclk[3] = ~tclk[3];

  clkcmp_top u0 (.clk(clk), .rst(rst), .tclk(tclk), .wr_en(wr_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .done_o(done_o), .err_o(err_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic setup(input int src, input int rs, input int ws, input int ts);
    wr(A_CTRL, 32'h5);
    wr(A_STAT, 32'h3);
    wr(A_REF, rs);
    wr(A_WIN, ws);
    wr(A_TST, ts);
    wr(A_SRC, 32'hA000 | src);
  endtask

  task automatic poll(output logic [31:0] s);
    s = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(A_STAT, s);
      if (s != 0) break;
    end
  endtask

  initial begin
    #(20ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    rd(A_STAT, rv); chk("R1 status", rv, 0);
    rd(A_CTRL, rv); chk("R1 ctrl key", rv, 32'h5);
    chk("R1 flags", {30'b0, done_o, err_o}, 0);

    // R3 R4 R5: vector table
    for (int v = 0; v < NV; v++) begin
      setup(V_SRC[v], V_REF[v], V_WIN[v], V_TST[v]);
      wr(A_CTRL, 32'hA);
      poll(rv);
      chk($sformatf("R3/R4/R5 vector %0d", v), rv, V_EXP[v]);
      chk($sformatf("R3/R4/R5 vector %0d pins", v), {30'b0, done_o, err_o}, V_EXP[v]);
    end

    // R6: clear error only with a one
    setup(0, 138, 10, 489);
    wr(A_CTRL, 32'hA); poll(rv);
    chk("R4 early err", rv, 1);
    wr(A_STAT, 32'h0); rd(A_STAT, rv); chk("R6 zero keeps err", rv, 1);
    wr(A_STAT, 32'h1); rd(A_STAT, rv); chk("R6 one clears err", rv, 0);

    // R2: corrupt key enables; R6 on done
    setup(3, 50, 10, 100);
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, rv); chk("R2 ctrl readback", rv, 3);
    poll(rv); chk("R2 odd key enables", rv, 2);
    wr(A_STAT, 32'h1); rd(A_STAT, rv); chk("R6 err bit keeps done", rv, 2);
    wr(A_STAT, 32'h2); rd(A_STAT, rv); chk("R6 one clears done", rv, 0);

    // R10: still enabled, no second result; key rewrite does not restart
    repeat (300) @(negedge clk);
    rd(A_STAT, rv); chk("R10 no repeat", rv, 0);
    wr(A_CTRL, 32'hA);
    repeat (300) @(negedge clk);
    rd(A_STAT, rv); chk("R2 R10 rewrite no restart", rv, 0);

    // R8: writes ignored while enabled
    wr(A_REF, 32'h7); rd(A_REF, rv); chk("R8 ref seed locked", rv, 50);
    wr(A_SRC, 32'hA001); rd(A_SRC, rv); chk("R8 source locked", rv, 3);
    // R2 R10: re-arm by disable then enable
    wr(A_CTRL, 32'h5);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'hA); poll(rv); chk("R10 rearm", rv, 2);

    // R7: keyed source select
    wr(A_CTRL, 32'h5);
    wr(A_SRC, 32'h3002); rd(A_SRC, rv); chk("R7 bad key ignored", rv, 3);
    wr(A_SRC, 32'hA002); rd(A_SRC, rv); chk("R7 good key", rv, 2);

    // R9: abort mid run
    setup(1, 138, 10, 489);
    wr(A_CTRL, 32'hA);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h5);
    repeat (300) @(negedge clk);
    rd(A_STAT, rv); chk("R9 abort no flag", rv, 0);
    chk("R9 abort pins", {30'b0, done_o, err_o}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule